// File: doc/BRIEF.md
# Two-Wire Write-Only Register Slave

This block is a slave on a two-wire serial bus (clock line plus open-drain data line) that accepts register writes and nothing else. The bus master opens a transaction with a start condition and sends an eight-bit header: a seven-bit device address followed by a direction bit. The slave answers only when the address equals its strapped address and the direction bit marks a write. The master then sends two payload bytes, and the slave acknowledges each one. Together the two bytes form a 16-bit control word: a 7-bit register address and a 9-bit data value.

Both bus lines enter the system clock domain through two-flop synchronizers. Bus events are taken from edges of the synchronized lines. The slave pulls the data line low only through an output enable, so the pad logic builds the open-drain driver from that enable. When the second acknowledge clock pulse ends, the block presents the assembled word together with a write strobe that lasts one system clock cycle. A start or stop condition that comes out of sequence cancels the transfer and returns the slave to idle, and no strobe is issued for that transfer.

Top module: `twi_wr_slave`

## Requirements
- R1: After reset the slave is idle, `sda_oe_o` is 0 (data line released) and `wr_valid_o` is 0.
- R2: A start condition is a falling edge on the data line while the clock line stays high. Only a start condition moves the idle slave into header reception.
- R3: The header is shifted in MSB first on clock rising edges: device address bits 6..0, then the direction bit (0 = write). If the address equals `dev_addr_i` and the direction bit is 0, the slave drives `sda_oe_o` = 1 for the whole ninth (acknowledge) clock pulse. It releases the line after the falling edge that ends that pulse.
- R4: If the header address differs from `dev_addr_i`, or the direction bit is 1, the slave does not acknowledge. It then keeps the line released and issues no strobe for the rest of that transaction.
- R5: After an accepted header, each of the two payload bytes is acknowledged on its ninth clock pulse.
- R6: The first payload byte carries register address bits 6..0 in its bits 7..1 and data bit 8 in its bit 0. The second payload byte carries data bits 7..0. Both bytes are MSB first. The word appears on `wr_addr_o` and `wr_data_o`.
- R7: `wr_valid_o` pulses high for exactly one system clock cycle, once per completed write, right after the falling clock edge that ends the second payload acknowledge.
- R8: A stop condition (rising edge on the data line while the clock line is high), or a start condition anywhere other than idle, returns the slave to idle at once. No strobe is issued, and nothing is acknowledged until the next start.
- R9: After a complete write, further bytes in the same transaction are not acknowledged and produce no strobe.
- R10: The value of `dev_addr_i` at the time of a header decides the match, so changing it between transactions retargets the slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_addr_i | input | 7 | Device address the slave answers to |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| wr_valid_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 7 | Register address of the completed write |
| wr_data_o | output | 9 | Data of the completed write |

## Verification
The hardest cases to reach are the aborts: a start or stop inside a payload byte, after the header has already been acknowledged. In that situation the slave must abandon a half-built word, and it must ignore the clock pulses the master keeps sending afterwards. The bench models a bus master with an open-drain data line. Its byte-level tasks can inject a start or stop between any two bits and then keep clocking the remaining bits. It checks that none of those later bits is acknowledged and that no strobe escapes, and it then proves recovery by running a clean write right after.

// File: rtl/twi_wr_pkg.sv
package twi_wr_pkg;
  localparam int unsigned DEV_AW = 7;
  localparam int unsigned REG_AW = 7;
  localparam int unsigned REG_DW = 9;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_HDR_ACK,
    ST_HI,
    ST_HI_ACK,
    ST_LO,
    ST_LO_ACK,
    ST_DONE
  } twi_st_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LINES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;  // idle bus reads high
      else         chain_q <= {chain_q[STAGES-2:0], d_i[l]};
    end
    assign q_o[l] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/twi_cond_det.sv
module twi_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_d_q, sda_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      scl_d_q <= scl_s_i;
      sda_d_q <= sda_s_i;
    end
  end

  logic scl_hold;
  assign scl_hold   = scl_d_q & scl_s_i;
  assign scl_rise_o = ~scl_d_q & scl_s_i;
  assign scl_fall_o = scl_d_q & ~scl_s_i;
  assign start_o    = scl_hold & sda_d_q & ~sda_s_i;
  assign stop_o     = scl_hold & ~sda_d_q & sda_s_i;
endmodule

// File: rtl/twi_rx_fsm.sv
module twi_rx_fsm
  import twi_wr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DEV_AW-1:0] dev_addr_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [REG_AW-1:0] wr_addr_o,
  output logic [REG_DW-1:0] wr_data_o,
  output twi_st_e           state_o
);
  twi_st_e           st_q;
  logic [BYTE_W-1:0] sh_q, hi_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              byte_end;

  assign byte_end = scl_fall_i && (cnt_q == CNT_W'(BYTE_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      sh_q       <= '0;
      hi_q       <= '0;
      cnt_q      <= '0;
      sda_oe_o   <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (stop_i || (start_i && st_q != ST_IDLE)) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (start_i) begin
            st_q  <= ST_HDR;
            cnt_q <= '0;
          end
          ST_HDR, ST_HI, ST_LO: begin
            if (scl_rise_i && cnt_q != CNT_W'(BYTE_W)) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_end) begin
              cnt_q <= '0;
              if (st_q == ST_HDR) begin
                if (sh_q[BYTE_W-1:1] == dev_addr_i && !sh_q[0]) begin
                  sda_oe_o <= 1'b1;
                  st_q     <= ST_HDR_ACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else if (st_q == ST_HI) begin
                hi_q     <= sh_q;
                sda_oe_o <= 1'b1;
                st_q     <= ST_HI_ACK;
              end else begin
                sda_oe_o <= 1'b1;
                st_q     <= ST_LO_ACK;
              end
            end
          end
          ST_HDR_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            st_q     <= ST_HI;
          end
          ST_HI_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            st_q     <= ST_LO;
          end
          ST_LO_ACK: if (scl_fall_i) begin
            sda_oe_o   <= 1'b0;
            wr_valid_o <= 1'b1;
            wr_addr_o  <= hi_q[BYTE_W-1:1];
            wr_data_o  <= {hi_q[0], sh_q};
            st_q       <= ST_DONE;
          end
          default: ;  // ST_DONE: only a stop or start leaves
        endcase
      end
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/twi_wr_slave.sv
module twi_wr_slave
  import twi_wr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DEV_AW-1:0] dev_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [REG_AW-1:0] wr_addr_o,
  output logic [REG_DW-1:0] wr_data_o
);
  logic    scl_s, sda_s;
  logic    scl_rise, scl_fall, start_det, stop_det;
  twi_st_e state;

  twi_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    ({scl_s, sda_s})
  );

  twi_cond_det u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  twi_rx_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dev_addr_i (dev_addr_i),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_oe_o   (sda_oe_o),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .state_o    (state)
  );
endmodule

// File: rtl/twi_wr_slave_chk.sv
module twi_wr_slave_chk
  import twi_wr_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    scl_s,
  input logic    start_det,
  input logic    stop_det,
  input twi_st_e state,
  input logic    sda_oe_o,
  input logic    wr_valid_o
);
  // R1: idle never drives the line
  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_oe_o);

  // R3: data line only changes while the bus clock is low
  a_r3_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s));

  // R7: single-cycle strobe
  a_r7_strobe_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  // R7: strobe follows the end of an acknowledge
  a_r7_strobe_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(sda_oe_o) && !sda_oe_o);

  // R8: stop always idles
  a_r8_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state == ST_IDLE) && !wr_valid_o);

  // R8: start outside idle aborts
  a_r8_start_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det && state != ST_IDLE) |=> (state == ST_IDLE));
endmodule

bind twi_wr_slave twi_wr_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s      (scl_s),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .state      (state),
  .sda_oe_o   (sda_oe_o),
  .wr_valid_o (wr_valid_o)
);

// File: tb/twi_wr_slave_tb.sv
module twi_wr_slave_tb;
  localparam int Q = 8;  // clk cycles per quarter bus bit

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] dev_addr = 7'h1A;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe, wr_valid;
  logic [6:0] wr_addr;
  logic [8:0] wr_data;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  twi_wr_slave u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .dev_addr_i (dev_addr),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .wr_valid_o (wr_valid),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(posedge clk);
  endtask

  // monitor: pops expected words on each strobe
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid && prev_valid) chk(0, "R7 strobe width", 2, 1);
      if (wr_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R7 unexpected strobe (R4/R8/R9)", {wr_addr, wr_data}, 0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk({wr_addr, wr_data} == e, "R6 word", {wr_addr, wr_data}, e);
        end
      end
    end
    prev_valid <= wr_valid;
  end

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic ack_slot(input bit exp, input string req);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    @(negedge clk);
    chk(sda_oe == exp, req, sda_oe, exp);
    chk(sda_line == !exp, {req, " line"}, sda_line, !exp);
    qwait();
    @(negedge clk);
    chk(sda_oe == exp, {req, " held"}, sda_oe, exp);
    scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] v, input bit exp, input string req);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    ack_slot(exp, req);
  endtask

  task automatic write_txn(input logic [6:0] dev, input bit rw,
                           input logic [6:0] ra, input logic [8:0] rd);
    bit ok;
    ok = (dev == dev_addr) && !rw;
    if (ok) exp_q.push_back({ra, rd});
    bus_start();
    send_byte({dev, rw}, ok, ok ? "R3 header ack" : "R4 header nack");
    send_byte({ra, rd[8]}, ok, ok ? "R5 byte1 ack" : "R4 byte1 nack");
    send_byte(rd[7:0], ok, ok ? "R5 byte2 ack" : "R4 byte2 nack");
    bus_stop();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);
    chk(wr_valid == 1'b0, "R1 reset strobe", wr_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(sda_oe == 1'b0, "R1 idle oe", sda_oe, 0);

    // R2 R3 R5 R6 R7: plain writes, boundary patterns
    write_txn(7'h1A, 1'b0, 7'h2C, 9'h0A5);
    write_txn(7'h1A, 1'b0, 7'h7F, 9'h1FF);
    write_txn(7'h1A, 1'b0, 7'h00, 9'h000);
    write_txn(7'h1A, 1'b0, 7'h55, 9'h100);  // R6 bit 8 from byte1 bit0

    // R4: address mismatch, read bit
    write_txn(7'h1B, 1'b0, 7'h11, 9'h022);
    write_txn(7'h1A, 1'b1, 7'h11, 9'h022);

    // R8: start inside byte1 after accepted header
    bus_start();
    send_byte({7'h1A, 1'b0}, 1'b1, "R3 header ack pre-abort");
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();  // out-of-sequence start
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    ack_slot(1'b0, "R8 no ack after start abort");
    send_byte(8'h3C, 1'b0, "R8 byte2 after start abort");
    bus_stop();
    repeat (4) @(posedge clk);

    // R8: stop inside byte2
    bus_start();
    send_byte({7'h1A, 1'b0}, 1'b1, "R3 header ack pre-stop");
    send_byte(8'h81, 1'b1, "R5 byte1 ack pre-stop");
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop();
    @(negedge clk);
    chk(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);
    write_txn(7'h1A, 1'b0, 7'h40, 9'h0C3);  // recovery

    // R9: extra byte after complete word
    exp_q.push_back({7'h12, 9'h134});
    bus_start();
    send_byte({7'h1A, 1'b0}, 1'b1, "R3 header ack R9");
    send_byte({7'h12, 1'b1}, 1'b1, "R5 byte1 ack R9");
    send_byte(8'h34, 1'b1, "R5 byte2 ack R9");
    send_byte(8'hEE, 1'b0, "R9 extra byte nack");
    bus_stop();
    repeat (4) @(posedge clk);

    // R10: retarget
    dev_addr = 7'h55;
    repeat (4) @(posedge clk);
    write_txn(7'h1A, 1'b0, 7'h01, 9'h001);
    write_txn(7'h55, 1'b0, 7'h6B, 9'h0F0);

    repeat (20) @(posedge clk);
    chk(exp_q.size() == 0, "R7 missing strobes", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule